// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte for every frame the transmit engine finishes and shows the oldest unread byte to the host on a byte-wide port. The host reads that byte, and any host write to the same port discards it so that the next oldest byte appears. Every completion event carries an "interrupt requested" flag and three error flags: jabber, underrun and maximum collisions. The stack has a fixed number of entries. When a completion arrives and the stack is full, the event is not stored. Instead the newest stored byte gets its overflow bit set, so the host can see that status was lost.

A 5-bit command pulse controls the block. Opcode 9 turns the transmitter on, opcode 10 turns it off, opcode 11 resets the transmit side and opcode 0 resets everything. A jabber or underrun completion locks the transmitter out. Only a transmit reset or a global reset clears that lockout. The block drives a TX-complete interrupt cause while the head entry needs attention. It also drives a halt flag while the transmitter is either switched off or locked out. All outputs are registered and reflect each clock edge's events right after that edge.

Top module: `txc_status_stack`

## Requirements
- R1: While `rst` is high and right after it falls, `status_byte` is 0x00, `tx_cause` is 0 and `tx_halted` is 1 (the transmitter starts switched off).
- R2: A stored entry reads as bit 7 = 1 (complete), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow and bits 1..0 = 0. Entries are shown oldest first. The outputs take their new values right after the clock edge that carried the event.
- R3: A `pop` pulse with a non-empty stack removes the head, and the next oldest entry appears after that edge. A `pop` with an empty stack has no effect.
- R4: With the stack empty, `status_byte` is 0x00.
- R5: The stack holds DEPTH entries (default 4). A completion that arrives while the stack is full and no pop happens in that cycle is not stored. It sets bit 2 of the newest stored entry instead.
- R6: When a pop and a completion land in the same cycle on a full stack, the completion is stored and no overflow bit is set. When they land on an empty stack, the completion is stored and the pop is ignored.
- R7: `tx_cause` is 1 exactly when the stack is non-empty and the head byte has any of bits 6..2 set.
- R8: A completion with jabber or underrun set drives `tx_halted` to 1. Opcode 9 does not release it. Only opcode 11 or opcode 0 releases it.
- R9: Opcode 9 switches the transmitter on and opcode 10 switches it off. `tx_halted` = switched off OR locked out.
- R10: Opcode 11 empties the stack and clears the lockout, and leaves the on/off state unchanged. Opcode 0 empties the stack, clears the lockout and switches the transmitter off.
- R11: A reset opcode (0 or 11) wins over a completion or pop in the same cycle, and that completion is discarded. Opcodes other than 0, 9, 10 and 11 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command pulse strobe |
| cmd_op | input | 5 | Command opcode (0, 9, 10, 11 decoded) |
| done_valid | input | 1 | Frame completion event |
| done_irq_req | input | 1 | Completion asks for an interrupt |
| done_jabber | input | 1 | Completion had a jabber error |
| done_underrun | input | 1 | Completion had an underrun |
| done_maxcoll | input | 1 | Completion hit maximum collisions |
| pop | input | 1 | Host write to the status port |
| status_byte | output | 8 | Oldest unread status byte, 0 when empty |
| tx_cause | output | 1 | TX-complete interrupt cause |
| tx_halted | output | 1 | Transmitter switched off or locked out |

## Verification
Two functions can fall in the same cycle: a host pop and a new completion, and a reset command and a completion. The pop-and-push case matters most on a full stack, where the block must store the event rather than mark overflow, and on an empty stack, where the pop must be ignored. The bench provokes both cases with directed steps and then with a long random sweep that forces many same-cycle collisions. It judges each cycle against a bench-side model of the stack, in which a pop is applied before the push and a reset command overrides both.

// File: rtl/txc_pkg.sv
package txc_pkg;

  localparam logic [4:0] OP_GLOBAL_RESET = 5'd0;
  localparam logic [4:0] OP_TX_ON        = 5'd9;
  localparam logic [4:0] OP_TX_OFF       = 5'd10;
  localparam logic [4:0] OP_TX_RESET     = 5'd11;

  typedef struct packed {
    logic irq;
    logic jabber;
    logic underrun;
    logic maxcoll;
  } txc_flags_t;

  function automatic logic [7:0] txc_pack(input txc_flags_t f, input logic ovf);
    return {1'b1, f.irq, f.jabber, f.underrun, f.maxcoll, ovf, 2'b00};
  endfunction

endpackage

// File: rtl/txc_cmd_decode.sv
module txc_cmd_decode
  import txc_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [4:0] cmd_op,
  output logic       glob_rst,
  output logic       tx_rst,
  output logic       tx_on,
  output logic       tx_off
);

  always_comb begin
    glob_rst = cmd_valid && (cmd_op == OP_GLOBAL_RESET);
    tx_rst   = cmd_valid && (cmd_op == OP_TX_RESET);
    tx_on    = cmd_valid && (cmd_op == OP_TX_ON);
    tx_off   = cmd_valid && (cmd_op == OP_TX_OFF);
  end

endmodule

// File: rtl/txc_entry_store.sv
module txc_entry_store
  import txc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       push,
  input  txc_flags_t push_flags,
  input  logic       pop_req,
  output logic       nxt_valid,
  output txc_flags_t nxt_flags,
  output logic       nxt_ovf
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  txc_flags_t mem [DEPTH];

  logic [AW-1:0]    head_q, tail_q, head_n, tail_n, newest;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [DEPTH-1:0] ovf_q, ovf_n;
  logic             full, nonempty, do_pop, do_wr, do_ovf;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full     = (cnt_q == CW'(DEPTH));
    nonempty = (cnt_q != '0);
    do_pop   = pop_req && nonempty && !flush;
    do_wr    = push && !flush && (!full || do_pop);
    do_ovf   = push && !flush && full && !do_pop;
    newest   = (tail_q == '0) ? LAST : tail_q - AW'(1);

    head_n = flush ? '0 : (do_pop ? bump(head_q) : head_q);
    tail_n = flush ? '0 : (do_wr  ? bump(tail_q) : tail_q);

    if (flush)                cnt_n = '0;
    else if (do_wr && !do_pop) cnt_n = cnt_q + CW'(1);
    else if (!do_wr && do_pop) cnt_n = cnt_q - CW'(1);
    else                       cnt_n = cnt_q;

    ovf_n = flush ? '0 : ovf_q;
    if (do_ovf) ovf_n[newest] = 1'b1;
    if (do_wr)  ovf_n[tail_q] = 1'b0;

    nxt_valid = (cnt_n != '0);
    nxt_flags = (do_wr && (tail_q == head_n)) ? push_flags : mem[head_n];
    nxt_ovf   = ovf_n[head_n];
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[tail_q] <= push_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
      ovf_q  <= ovf_n;
    end
  end

endmodule

// File: rtl/txc_tx_gate.sv
module txc_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic glob_rst,
  input  logic tx_rst,
  input  logic tx_on,
  input  logic tx_off,
  input  logic err_evt,
  output logic tx_halted
);

  logic on_q, on_n, lock_q, lock_n;

  always_comb begin
    on_n   = on_q;
    lock_n = lock_q;
    if (glob_rst) begin
      on_n   = 1'b0;
      lock_n = 1'b0;
    end else if (tx_rst) begin
      lock_n = 1'b0;
    end else begin
      if (tx_on)   on_n   = 1'b1;
      if (tx_off)  on_n   = 1'b0;
      if (err_evt) lock_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q      <= 1'b0;
      lock_q    <= 1'b0;
      tx_halted <= 1'b1;
    end else begin
      on_q      <= on_n;
      lock_q    <= lock_n;
      tx_halted <= !on_n || lock_n;
    end
  end

endmodule

// File: rtl/txc_status_stack.sv
module txc_status_stack
  import txc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [4:0] cmd_op,
  input  logic       done_valid,
  input  logic       done_irq_req,
  input  logic       done_jabber,
  input  logic       done_underrun,
  input  logic       done_maxcoll,
  input  logic       pop,
  output logic [7:0] status_byte,
  output logic       tx_cause,
  output logic       tx_halted
);

  logic       glob_rst, tx_rst, tx_on, tx_off;
  logic       nxt_valid, nxt_ovf;
  txc_flags_t in_flags, nxt_flags;

  assign in_flags = '{irq: done_irq_req, jabber: done_jabber,
                      underrun: done_underrun, maxcoll: done_maxcoll};

  txc_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .glob_rst  (glob_rst),
    .tx_rst    (tx_rst),
    .tx_on     (tx_on),
    .tx_off    (tx_off)
  );

  txc_entry_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst        (rst),
    .flush      (glob_rst || tx_rst),
    .push       (done_valid),
    .push_flags (in_flags),
    .pop_req    (pop),
    .nxt_valid  (nxt_valid),
    .nxt_flags  (nxt_flags),
    .nxt_ovf    (nxt_ovf)
  );

  txc_tx_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .glob_rst  (glob_rst),
    .tx_rst    (tx_rst),
    .tx_on     (tx_on),
    .tx_off    (tx_off),
    .err_evt   (done_valid && (done_jabber || done_underrun)),
    .tx_halted (tx_halted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_byte <= 8'h00;
      tx_cause    <= 1'b0;
    end else begin
      status_byte <= nxt_valid ? txc_pack(nxt_flags, nxt_ovf) : 8'h00;
      tx_cause    <= nxt_valid && (nxt_flags.irq || nxt_flags.jabber ||
                     nxt_flags.underrun || nxt_flags.maxcoll || nxt_ovf);
    end
  end

endmodule

// File: rtl/txc_status_stack_chk.sv
module txc_status_stack_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [4:0] cmd_op,
  input logic       done_valid,
  input logic       done_jabber,
  input logic       done_underrun,
  input logic       pop,
  input logic [7:0] status_byte,
  input logic       tx_cause,
  input logic       tx_halted
);

  logic any_rst_cmd;
  assign any_rst_cmd = cmd_valid && (cmd_op == 5'd0 || cmd_op == 5'd11);

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    !status_byte[7] |-> status_byte == 8'h00);  // R4

  AST_CAUSE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    tx_cause |-> status_byte[7] && (status_byte[6:2] != 5'd0));  // R7

  AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 5'd0) |=> status_byte == 8'h00 && tx_halted);  // R10

  AST_TXRST_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 5'd11) |=> status_byte == 8'h00 && !tx_cause);  // R11

  AST_ERR_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (done_valid && (done_jabber || done_underrun) && !any_rst_cmd) |=> tx_halted);  // R8

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (tx_halted && !cmd_valid) |=> tx_halted);  // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!done_valid && !pop && !cmd_valid) |=> $stable(status_byte) && $stable(tx_cause));  // R3

endmodule

bind txc_status_stack txc_status_stack_chk u_chk (.*);

// File: tb/tb_txc_status_stack.sv
module tb_txc_status_stack;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid;
  logic [4:0] cmd_op;
  logic       done_valid, done_irq_req, done_jabber, done_underrun, done_maxcoll;
  logic       pop;
  logic [7:0] status_byte;
  logic       tx_cause, tx_halted;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mq [D];
  int         mcnt;
  bit         mon, mlock;

  txc_status_stack #(.DEPTH(D)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .done_valid(done_valid), .done_irq_req(done_irq_req),
    .done_jabber(done_jabber), .done_underrun(done_underrun),
    .done_maxcoll(done_maxcoll), .pop(pop),
    .status_byte(status_byte), .tx_cause(tx_cause), .tx_halted(tx_halted)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [7:0] eb;
    logic       ec;
    eb = (mcnt > 0) ? mq[0] : 8'h00;
    ec = (mcnt > 0) && (mq[0][6:2] != 5'd0);
    chk({tag, " byte"}, status_byte, eb);
    chk({tag, " cause"}, {7'd0, tx_cause}, {7'd0, ec});
    chk({tag, " halt"}, {7'd0, tx_halted}, {7'd0, (!mon || mlock)});
  endtask

  task automatic model_step(input bit cv, input logic [4:0] op, input bit dv,
                            input bit i, input bit j, input bit u, input bit m, input bit pp);
    if (cv && op == 5'd0) begin
      mcnt = 0; mlock = 0; mon = 0;
    end else if (cv && op == 5'd11) begin
      mcnt = 0; mlock = 0;
    end else begin
      if (cv && op == 5'd9)  mon = 1;
      if (cv && op == 5'd10) mon = 0;
      if (dv && (j || u)) mlock = 1;
      if (pp && mcnt > 0) begin
        for (int k = 0; k < D - 1; k++) mq[k] = mq[k+1];
        mcnt--;
      end
      if (dv) begin
        if (mcnt < D) begin
          mq[mcnt] = {1'b1, i, j, u, m, 1'b0, 2'b00};
          mcnt++;
        end else begin
          mq[D-1][2] = 1'b1;
        end
      end
    end
  endtask

  task automatic drive(input bit cv, input logic [4:0] op, input bit dv,
                       input bit i, input bit j, input bit u, input bit m, input bit pp);
    cmd_valid = cv; cmd_op = op; done_valid = dv; done_irq_req = i;
    done_jabber = j; done_underrun = u; done_maxcoll = m; pop = pp;
    @(posedge clk);
    model_step(cv, op, dv, i, j, u, m, pp);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0; done_valid = 0; done_irq_req = 0;
    done_jabber = 0; done_underrun = 0; done_maxcoll = 0; pop = 0;
  endtask

  task automatic cmd(input logic [4:0] op);
    drive(1, op, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic push(input bit i, input bit j, input bit u, input bit m);
    drive(0, 5'd0, 1, i, j, u, m, 0);
  endtask

  task automatic popit();
    drive(0, 5'd0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; cmd_valid = 0; cmd_op = 0; done_valid = 0; done_irq_req = 0;
    done_jabber = 0; done_underrun = 0; done_maxcoll = 0; pop = 0;
    mcnt = 0; mon = 0; mlock = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset byte", status_byte, 8'h00);
    chk("R1 reset halt", {7'd0, tx_halted}, 8'h01);
    rst = 0;
    @(negedge clk);
    chk_all("R1");

    cmd(5'd9);                   chk_all("R9 enable");
    chk("R9 running", {7'd0, tx_halted}, 8'h00);
    push(0, 0, 0, 0);            chk("R2 plain", status_byte, 8'h80);
    chk("R7 no cause", {7'd0, tx_cause}, 8'h00);
    push(1, 0, 0, 0);            chk("R2 oldest first", status_byte, 8'h80);
    popit();                     chk("R3 next", status_byte, 8'hC0);
    chk("R7 irq cause", {7'd0, tx_cause}, 8'h01);
    popit();                     chk("R4 empty", status_byte, 8'h00);
    popit();                     chk("R3 pop empty", status_byte, 8'h00);
    chk_all("R3");

    push(0, 0, 0, 1); push(1, 0, 0, 0); push(0, 0, 0, 0); push(1, 0, 0, 1);
    chk_all("R5 fill");
    push(0, 0, 0, 0);            chk_all("R5 overflow");
    drive(0, 5'd0, 1, 0, 0, 0, 1, 1); chk_all("R6 full pop+push");
    popit(); popit(); popit();   chk_all("R5 newest");
    chk("R6 last stored", status_byte, 8'h88);
    popit();                     chk_all("R4");
    drive(0, 5'd0, 1, 1, 0, 0, 0, 1); chk("R6 empty pop+push", status_byte, 8'hC0);

    push(0, 1, 0, 0);            chk_all("R8 jabber");
    chk("R8 halted", {7'd0, tx_halted}, 8'h01);
    cmd(5'd9);                   chk("R8 on ignored", {7'd0, tx_halted}, 8'h01);
    cmd(5'd11);                  chk_all("R10 tx reset");
    chk("R10 released", {7'd0, tx_halted}, 8'h00);
    push(0, 0, 1, 0);            chk("R8 underrun", {7'd0, tx_halted}, 8'h01);
    cmd(5'd0);                   chk_all("R10 global");
    cmd(5'd9);                   chk_all("R9 on");
    push(1, 0, 0, 0);
    drive(1, 5'd11, 1, 0, 1, 0, 0, 1); chk_all("R11 reset wins");
    chk("R11 dropped", status_byte, 8'h00);
    push(1, 0, 0, 0);
    cmd(5'd5);                   chk_all("R11 other op");
    cmd(5'd10);                  chk_all("R9 off");

    for (int n = 0; n < 6000; n++) begin
      bit cv, dv, pp, i, j, u, m;
      logic [4:0] op;
      int r;
      cv = ($urandom_range(0, 15) == 0);
      r  = $urandom_range(0, 9);
      op = (r < 4) ? 5'd9 : (r < 6) ? 5'd10 : (r < 8) ? 5'd11 : (r < 9) ? 5'd3 : 5'd0;
      dv = $urandom_range(0, 1);
      pp = ($urandom_range(0, 2) == 0);
      i  = $urandom_range(0, 1);
      m  = $urandom_range(0, 1);
      j  = ($urandom_range(0, 15) == 0);
      u  = ($urandom_range(0, 15) == 0);
      drive(cv, op, dv, i, j, u, m, pp);
      chk_all("R2 R5 R6 R7 R8 sweep");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule